// File: doc/BRIEF.md
# Cell Rate Transmit Scheduler

This block decides, once per fixed cell slot, which of several transmit virtual channels may send the next cell. Each source is shaped by a credit ratio: it may send I cells in every M cell slots. Every source also carries a priority level. A ninth source stands for an unassigned-cell generator. It is scheduled like a data channel. When it is given a high priority and a nonzero ratio, it takes its share of slots, and the spacing between all data cells grows by that share.

Software programs each source through a single-cycle write port. One strobe writes the ratio and the priority. A second strobe switches a source on or off. When a slot goes to a data channel, the block raises a fetch request for that channel's cell data. While the downstream transmit FIFO reports full, the request is held back and no cell is lost. If a held request is still outstanding when the next slot boundary arrives, that boundary is skipped. No decision is made and no credit moves.

Top module: `txcell_rate_sched`

## Requirements
- R1: A decision is made every SLOT_CLKS (default 24) clock cycles. It is marked by `dec_strobe` being high for exactly one cycle, unless the slot is skipped under R7.
- R2: Each active source keeps a credit counter.
  - The counter is cleared by any accepted write or activation write to that source.
  - The source is eligible when M is nonzero and credit is at least M.
  - At each decision, the winner's credit changes by I minus M.
  - An eligible source that loses keeps its credit unchanged.
  - A source that is not eligible gains I.
- R3: Among eligible sources, the highest `prio` value wins. Ties go to the lowest source index. The unassigned-cell source has index NCH, so it loses every tie against a data channel.
- R4: `dec_kind` encodes the outcome of the decision: 0 = idle, 1 = data cell, 2 = unassigned cell. `dec_chan` carries the winning data channel index, and is 0 for idle and unassigned decisions.
- R5: A data decision raises `fetch_req` for one cycle. If the FIFO is not full, this happens in the same cycle as `dec_strobe`. Idle and unassigned decisions never raise it.
- R6: While `fifo_full` is high, a pending fetch is withheld and `dec_chan` stays stable. `fetch_req` rises in the first cycle in which `fifo_full` is low.
- R7: At a slot boundary where a fetch is still withheld, no decision is made and no credit changes.
- R8: `cfg_sel` 0..NCH-1 selects a data channel and NCH selects the unassigned source. A ratio write with M = 0 or I > M is rejected and has no effect at all.
- R9: An inactive source never wins a slot.
- R10: While reset is applied and after it is released, `dec_strobe`, `dec_kind`, `dec_chan` and `fetch_req` are 0 until the first decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Ratio and priority write strobe |
| cfg_sel | input | 4 | Source select (NCH = unassigned source) |
| cfg_i | input | 16 | Cells allowed per window (I) |
| cfg_m | input | 16 | Window length in slots (M) |
| cfg_prio | input | 2 | Priority, higher wins |
| act_we | input | 1 | Activation write strobe |
| act_on | input | 1 | New activation state |
| fifo_full | input | 1 | Transmit FIFO full |
| dec_strobe | output | 1 | One-cycle decision marker |
| dec_kind | output | 2 | Decision outcome code |
| dec_chan | output | 3 | Chosen data channel |
| fetch_req | output | 1 | Cell fetch request |

## Verification
The hardest state to reach is the skipped slot of R7. It requires a data decision whose fetch is still withheld when the next slot boundary arrives. The bench brings it about by raising `fifo_full` just before a decision for a channel that wins every slot. It then holds `fifo_full` across the following boundary, confirms that no strobe appears there, and releases the FIFO. Finally it checks that the request appears at once and that later decisions still match a credit model that took no step for the skipped slot. Credit behaviour is covered by sweeping every ratio with M up to 5 on a single channel, attempting a rejected write each time.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic [1:0] {
    DK_IDLE       = 2'd0,
    DK_DATA       = 2'd1,
    DK_UNASSIGNED = 2'd2
  } dec_kind_e;
endpackage

// File: rtl/txs_slot_timer.sv
module txs_slot_timer #(
  parameter int SLOT_CLKS = 24
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int TW = $clog2(SLOT_CLKS);
  localparam logic [TW-1:0] LAST = TW'(SLOT_CLKS - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (cnt_q == LAST) cnt_d = '0;
  end

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1: the counter never leaves its range
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/txs_rate_acc.sv
module txs_rate_acc #(
  parameter int RW  = 16,
  parameter int PW  = 2,
  parameter int SW  = 4,
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_sel,
  input  logic [RW-1:0] cfg_i,
  input  logic [RW-1:0] cfg_m,
  input  logic [PW-1:0] cfg_prio,
  input  logic          act_we,
  input  logic          act_on,
  input  logic          tick,
  input  logic          stall,
  input  logic          grant,
  output logic          elig,
  output logic [PW-1:0] prio
);
  logic          hit, cfg_ok, wr_ok, act_hit, adv;
  logic [RW-1:0] i_q, i_d, m_q, m_d;
  logic [PW-1:0] p_q, p_d;
  logic          on_q, on_d;
  logic [RW:0]   acc_q, acc_d;

  assign hit     = (cfg_sel == SW'(IDX));
  assign cfg_ok  = (cfg_m != '0) && (cfg_i <= cfg_m);
  assign wr_ok   = cfg_we && hit && cfg_ok;
  assign act_hit = act_we && hit;
  assign adv     = tick && !stall && on_q;

  assign elig = on_q && (m_q != '0) && (acc_q >= {1'b0, m_q});
  assign prio = p_q;

  always_comb begin
    i_d   = i_q;
    m_d   = m_q;
    p_d   = p_q;
    on_d  = on_q;
    acc_d = acc_q;
    if (adv) begin
      if (grant)      acc_d = acc_q - {1'b0, m_q} + {1'b0, i_q};
      else if (!elig) acc_d = acc_q + {1'b0, i_q};
    end
    if (wr_ok) begin
      i_d = cfg_i;
      m_d = cfg_m;
      p_d = cfg_prio;
    end
    if (act_hit) on_d = act_on;
    if (wr_ok || act_hit) acc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q   <= '0;
      m_q   <= '0;
      p_q   <= '0;
      on_q  <= 1'b0;
      acc_q <= '0;
    end else begin
      i_q   <= i_d;
      m_q   <= m_d;
      p_q   <= p_d;
      on_q  <= on_d;
      acc_q <= acc_d;
    end
  end

  // R2: credit stays below twice the window
  p_acc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q && m_q != '0) |-> (acc_q < {m_q, 1'b0}));
  // R8: a rejected write leaves the ratio and priority untouched
  p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && hit && !cfg_ok) |=> ($stable(i_q) && $stable(m_q) && $stable(p_q)));
  // R3/R9: a grant only reaches an eligible, active source
  p_grant_elig_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (elig && on_q));
endmodule

// File: rtl/txs_pick.sv
module txs_pick #(
  parameter int NSRC = 9,
  parameter int PW   = 2,
  parameter int SW   = 4
) (
  input  logic [NSRC-1:0]         elig,
  input  logic [NSRC-1:0][PW-1:0] prio,
  output logic                    any,
  output logic [SW-1:0]           win
);
  logic [PW-1:0] best;

  always_comb begin
    any  = 1'b0;
    win  = '0;
    best = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (elig[k] && (!any || prio[k] >= best)) begin
        any  = 1'b1;
        win  = SW'(k);
        best = prio[k];
      end
    end
  end
endmodule

// File: rtl/txcell_rate_sched.sv
module txcell_rate_sched #(
  parameter int NCH       = 8,
  parameter int RW        = 16,
  parameter int PW        = 2,
  parameter int SLOT_CLKS = 24,
  localparam int NSRC     = NCH + 1,
  localparam int SW       = $clog2(NSRC),
  localparam int CW       = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_sel,
  input  logic [RW-1:0] cfg_i,
  input  logic [RW-1:0] cfg_m,
  input  logic [PW-1:0] cfg_prio,
  input  logic          act_we,
  input  logic          act_on,
  input  logic          fifo_full,
  output logic          dec_strobe,
  output logic [1:0]    dec_kind,
  output logic [CW-1:0] dec_chan,
  output logic          fetch_req
);
  import txs_pkg::*;

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic                    tick, stall, decide, any;
  logic [SW-1:0]           win;
  logic [NSRC-1:0]         elig, grant;
  logic [NSRC-1:0][PW-1:0] prio;

  txs_slot_timer #(.SLOT_CLKS(SLOT_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_sync_q), .tick(tick)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    txs_rate_acc #(.RW(RW), .PW(PW), .SW(SW), .IDX(g)) u_acc (
      .clk(clk), .rst_n(rst_sync_q),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_i(cfg_i), .cfg_m(cfg_m),
      .cfg_prio(cfg_prio), .act_we(act_we), .act_on(act_on),
      .tick(tick), .stall(stall), .grant(grant[g]),
      .elig(elig[g]), .prio(prio[g])
    );
    assign grant[g] = decide && any && (win == SW'(g));

    // R3: no eligible source outranks the winner
    p_pick_rank_r3: assert property (@(posedge clk) disable iff (!rst_sync_q)
      (decide && elig[g]) |->
        (any && ((prio[g] < prio[win]) || (prio[g] == prio[win] && win <= SW'(g)))));
  end

  txs_pick #(.NSRC(NSRC), .PW(PW), .SW(SW)) u_pick (
    .elig(elig), .prio(prio), .any(any), .win(win)
  );

  logic          strobe_q, strobe_d, pend_q, pend_d;
  dec_kind_e     kind_q, kind_d;
  logic [CW-1:0] chan_q, chan_d;

  assign fetch_req = pend_q && !fifo_full;
  assign stall     = tick && pend_q && fifo_full;
  assign decide    = tick && !stall;

  always_comb begin
    strobe_d = decide;
    kind_d   = kind_q;
    chan_d   = chan_q;
    pend_d   = pend_q;
    if (fetch_req) pend_d = 1'b0;
    if (decide) begin
      chan_d = '0;
      if (!any) begin
        kind_d = DK_IDLE;
      end else if (win == SW'(NCH)) begin
        kind_d = DK_UNASSIGNED;
      end else begin
        kind_d = DK_DATA;
        chan_d = win[CW-1:0];
        pend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      strobe_q <= 1'b0;
      kind_q   <= DK_IDLE;
      chan_q   <= '0;
      pend_q   <= 1'b0;
    end else begin
      strobe_q <= strobe_d;
      kind_q   <= kind_d;
      chan_q   <= chan_d;
      pend_q   <= pend_d;
    end
  end

  assign dec_strobe = strobe_q;
  assign dec_kind   = kind_q;
  assign dec_chan   = chan_q;

  // R1: a decision marker lasts a single cycle
  p_strobe_gap_r1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    dec_strobe |=> !dec_strobe);
  // R5: fetch requests belong to data decisions only
  p_fetch_data_r5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    fetch_req |-> (kind_q == DK_DATA));
  // R6: a withheld fetch keeps its channel
  p_hold_full_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (pend_q && fifo_full) |=> (pend_q && $stable(dec_chan)));
  // R7: a boundary with a withheld fetch produces no decision
  p_stall_skip_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (tick && pend_q && fifo_full) |=> !dec_strobe);
endmodule

// File: tb/txcell_rate_sched_test.sv
module txcell_rate_sched_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [15:0] cfg_i = '0;
  logic [15:0] cfg_m = '0;
  logic [1:0]  cfg_prio = '0;
  logic        act_we = 1'b0;
  logic        act_on = 1'b0;
  logic        fifo_full = 1'b0;
  logic        dec_strobe, fetch_req;
  logic [1:0]  dec_kind;
  logic [2:0]  dec_chan;

  txcell_rate_sched uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_i(cfg_i), .cfg_m(cfg_m), .cfg_prio(cfg_prio), .act_we(act_we),
    .act_on(act_on), .fifo_full(fifo_full), .dec_strobe(dec_strobe),
    .dec_kind(dec_kind), .dec_chan(dec_chan), .fetch_req(fetch_req)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int mi[9], mm[9], mp[9], macc[9];
  bit mon[9];
  int since = 0;
  int last_gap = 0;

  initial forever begin
    @(negedge clk);
    if (dec_strobe) begin last_gap = since; since = 1; end
    else since++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual hang expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input int sel, input int i, input int m, input int p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_i = 16'(i); cfg_m = 16'(m); cfg_prio = 2'(p);
    @(negedge clk);
    cfg_we = 1'b0;
    if (m != 0 && i <= m) begin
      mi[sel] = i; mm[sel] = m; mp[sel] = p; macc[sel] = 0;
    end
  endtask

  task automatic wr_act(input int sel, input bit on);
    @(negedge clk);
    act_we = 1'b1; cfg_sel = 4'(sel); act_on = on;
    @(negedge clk);
    act_we = 1'b0;
    mon[sel] = on; macc[sel] = 0;
  endtask

  task automatic model_decide(output int kind, output int chan);
    bit el[9];
    int best = -1;
    for (int s = 0; s < 9; s++) begin
      el[s] = mon[s] && mm[s] != 0 && macc[s] >= mm[s];
      if (el[s] && (best < 0 || mp[s] > mp[best])) best = s;
    end
    for (int s = 0; s < 9; s++) begin
      if (mon[s]) begin
        if (s == best) macc[s] = macc[s] - mm[s] + mi[s];
        else if (!el[s]) macc[s] = macc[s] + mi[s];
      end
    end
    kind = (best < 0) ? 0 : (best == 8) ? 2 : 1;
    chan = (kind == 1) ? best : 0;
  endtask

  task automatic next_dec();
    int n = 0;
    do begin @(negedge clk); n++; end while (!dec_strobe && n < 200);
    chk(dec_strobe, "R1 strobe seen", int'(dec_strobe), 1);
  endtask

  task automatic check_slot(input string req, input bit gap_chk);
    int k, c;
    next_dec();
    #1;
    model_decide(k, c);
    chk(dec_kind == 2'(k), {req, " kind"}, int'(dec_kind), k);
    chk(dec_chan == 3'(c), {req, " chan"}, int'(dec_chan), c);
    if (!fifo_full) chk(fetch_req == (k == 1), "R5 fetch with decision", int'(fetch_req), int'(k == 1));
    if (gap_chk) chk(last_gap == 24, "R1 slot period", last_gap, 24);
  endtask

  task automatic all_off();
    for (int s = 0; s < 9; s++) wr_act(s, 1'b0);
  endtask

  initial begin
    for (int s = 0; s < 9; s++) begin mi[s] = 0; mm[s] = 0; mp[s] = 0; macc[s] = 0; mon[s] = 0; end
    repeat (3) @(negedge clk);
    chk(!dec_strobe && dec_kind == 0 && dec_chan == 0 && !fetch_req, "R10 in reset",
        int'({dec_strobe, dec_kind, dec_chan, fetch_req}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!dec_strobe && dec_kind == 0 && dec_chan == 0 && !fetch_req, "R10 after release",
        int'({dec_strobe, dec_kind, dec_chan, fetch_req}), 0);

    // R4 idle slots while nothing is active
    check_slot("R4 idle", 1'b0);
    check_slot("R4 idle", 1'b1);

    // R2/R8 sweep of every ratio with M up to 5 on channel 0
    for (int m = 1; m <= 5; m++) begin
      for (int i = 0; i <= m; i++) begin
        wr_cfg(0, i, m, 1);
        wr_act(0, 1'b1);
        for (int t = 0; t < m + 3; t++) check_slot("R2 ratio", 1'b1);
        wr_cfg(0, m + 1, m, 3);   // R8: rejected, credit continues
        wr_cfg(0, 0, 0, 2);       // R8: M = 0 rejected
        for (int t = 0; t < m + 3; t++) check_slot("R8 rejected write", 1'b1);
      end
    end

    // R3 priorities, ties and unassigned source share
    check_slot("R3 sync", 1'b0);
    all_off();
    wr_cfg(0, 1, 1, 1); wr_cfg(2, 1, 2, 2); wr_cfg(5, 1, 2, 2);
    wr_cfg(7, 2, 3, 0); wr_cfg(8, 1, 3, 3);
    wr_act(0, 1'b1); wr_act(2, 1'b1); wr_act(5, 1'b1); wr_act(7, 1'b1); wr_act(8, 1'b1);
    for (int t = 0; t < 30; t++) check_slot("R3 ranking", 1'b1);

    // R3 tie between unassigned source and a data channel
    check_slot("R3 sync", 1'b0);
    all_off();
    wr_cfg(4, 1, 1, 1); wr_cfg(8, 1, 1, 1);
    wr_act(4, 1'b1); wr_act(8, 1'b1);
    for (int t = 0; t < 6; t++) check_slot("R3 tie to data", 1'b1);

    // R9 deactivated channel never wins; unassigned takes half the slots
    wr_act(4, 1'b0);
    wr_cfg(8, 1, 2, 3); wr_act(8, 1'b1);
    wr_cfg(6, 1, 1, 0); wr_act(6, 1'b1);
    for (int t = 0; t < 10; t++) check_slot("R9 inactive ignored", 1'b1);

    // R6/R7 withheld fetch and skipped slot
    check_slot("R6 sync", 1'b0);
    all_off();
    wr_cfg(3, 1, 1, 0); wr_act(3, 1'b1);
    check_slot("R6 warmup", 1'b0);
    check_slot("R6 first grant", 1'b1);
    @(negedge clk); fifo_full = 1'b1;
    check_slot("R6 decision under full", 1'b1);
    chk(!fetch_req, "R6 withheld", int'(fetch_req), 0);
    begin
      int seen = 0;
      int reqs = 0;
      for (int n = 0; n < 30; n++) begin
        @(negedge clk);
        if (dec_strobe) seen++;
        if (fetch_req) reqs++;
      end
      chk(seen == 0, "R7 no decision while held", seen, 0);
      chk(reqs == 0, "R6 no request while full", reqs, 0);
      chk(dec_chan == 3'd3, "R6 chan stable", int'(dec_chan), 3);
    end
    fifo_full = 1'b0;
    #1;
    chk(fetch_req, "R6 request on release", int'(fetch_req), 1);
    @(negedge clk);
    chk(!fetch_req, "R5 single cycle request", int'(fetch_req), 0);
    for (int t = 0; t < 4; t++) check_slot("R7 credit frozen", 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule